// File: doc/BRIEF.md
# Configurable Output Macrocell Array

This block is the output stage of a sum-of-products logic array. A shared AND plane, which sits outside the block, presents its product terms as a flat vector. The block holds ten output cells. Each cell ORs its own slice of that vector into one sum. The slices have different widths, from 8 to 16 terms. A cell either drives that sum straight to its pin or drives it from a flip-flop clocked on the rising edge.

Two configuration bits per cell set its behaviour. One bit picks registered or combinational operation. The other picks active-high or active-low output, and it applies after the register, so both modes honour it. Because every cell is set on its own, any mix of registered and combinational outputs, and of polarities, can be built from one block.

Each cell also has a dedicated product term for its output enable. Two shared terms act on every register at once: one clears them asynchronously, the other presets them on the clock edge. A feedback bit returns to the AND plane from each cell. In registered mode it comes from the register. In combinational mode it comes from the pad.

Top module: `mcarr_top`

## Requirements
- R1: Cell i ORs a contiguous slice of `pt_sum`. The slice widths for cells 0 to 9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. The slices are packed from bit 0 upward, with cell 0 lowest, so cell 0 uses bits 7:0 and cell 9 uses bits 119:112.
- R2: When `cfg_reg[i]`=1, the cell's output data comes from a register that captures the OR sum on each rising edge of `clk`.
- R3: When `cfg_reg[i]`=0, `pin_out[i]` follows the OR sum within the same cycle, with no clock edge in between.
- R4: When `cfg_pol[i]`=1, the data reaches the pin unchanged. When it is 0, the data is inverted. This applies after the register, in both modes.
- R5: `pin_oe[i]` equals the cell's enable term `pt_oe[i]` at all times, in either mode.
- R6: While `pt_aclr`=1, every register is 0 at once, without waiting for a clock edge. The clear overrides the preset.
- R7: When `pt_spre`=1 at a rising edge and `pt_aclr`=0, every register becomes 1, whatever its OR sum.
- R8: `fb_out[i]` is the register content, before polarity, when `cfg_reg[i]`=1. It is `pin_in[i]` when `cfg_reg[i]`=0.
- R9: Each cell follows its own two configuration bits, whatever the settings of the other cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| pt_aclr | input | 1 | Shared term, asynchronous clear of all registers |
| pt_spre | input | 1 | Shared term, synchronous preset of all registers |
| pt_sum | input | 120 | Product terms feeding the OR gates of all cells |
| pt_oe | input | 10 | Output-enable term, one per cell |
| cfg_reg | input | 10 | 1 = registered, 0 = combinational, per cell |
| cfg_pol | input | 10 | 1 = active-high, 0 = active-low, per cell |
| pin_in | input | 10 | Pad level, used as feedback in combinational mode |
| pin_out | output | 10 | Output data after polarity |
| pin_oe | output | 10 | Output driver enable |
| fb_out | output | 10 | Feedback to the AND plane |

## Verification
The clocked assertions assume that `pt_aclr` and the other inputs change only away from the rising edge of `clk`. They also assume that the configuration bits hold steady across the edge they are checked over. The stimulus meets both assumptions by changing every input at the falling edge only. The one exception is the asynchronous clear test: it raises `pt_aclr` at a falling edge and samples the pins a moment later, before any rising edge. The bench drives `pin_in` on its own, separate from `pin_out`, so that the feedback source can be told apart.

// File: rtl/mcarr_pkg.sv
package mcarr_pkg;

    localparam int NCELL_DEF = 10;
    localparam int MIN_TERMS = 8;
    localparam int MAX_TERMS = 16;
    localparam int TERM_STEP = 2;

    // Width of each OR slice: it ramps up toward the middle of the array and down again.
    function automatic int term_count(input int idx, input int ncell);
        int rank;
        int w;
        rank = (idx < ncell / 2) ? idx : (ncell - 1 - idx);
        w = MIN_TERMS + TERM_STEP * rank;
        return (w > MAX_TERMS) ? MAX_TERMS : w;
    endfunction

    // Lowest bit of a cell's slice in the flat term vector.
    function automatic int term_base(input int idx, input int ncell);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += term_count(k, ncell);
        return acc;
    endfunction

    function automatic int term_total(input int ncell);
        return term_base(ncell, ncell);
    endfunction

    typedef struct packed {
        logic registered;
        logic act_high;
    } cell_cfg_t;

    typedef struct packed {
        logic data;
        logic oe;
        logic fb;
    } cell_out_t;

endpackage

// File: rtl/mcarr_or.sv
module mcarr_or #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] terms,
    output logic             sum
);
    assign sum = |terms;
endmodule

// File: rtl/mcarr_cell.sv
module mcarr_cell
    import mcarr_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             spre,
    input  logic [NTERM-1:0] terms,
    input  logic             oe_term,
    input  cell_cfg_t        cfg,
    input  logic             pad,
    output cell_out_t        o
);
    logic sum;
    logic q;
    logic pre_pol;

    mcarr_or #(.WIDTH(NTERM)) i_or (
        .terms (terms),
        .sum   (sum)
    );

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr)      q <= 1'b0;
        else if (spre) q <= 1'b1;
        else           q <= sum;
    end

    always_comb begin
        pre_pol = cfg.registered ? q : sum;
        o.data  = cfg.act_high ? pre_pol : ~pre_pol;
        o.oe    = oe_term;
        o.fb    = cfg.registered ? q : pad;
    end

    // R6: with the clear term high, the register is already empty at any edge.
    a_r6_clear_holds: assert property (@(posedge clk) aclr |-> !q);

    // R7: the preset term loads a one at the next edge.
    a_r7_preset_loads: assert property (@(posedge clk) disable iff (aclr)
        spre |=> q);

    // R2: without preset, the register takes the previous cycle's OR sum.
    a_r2_captures_sum: assert property (@(posedge clk) disable iff (aclr)
        !spre |=> (q == $past(sum)));

    // R4: in registered mode the pin shows last cycle's sum, inverted when active-low.
    a_r4_pol_after_reg: assert property (@(posedge clk) disable iff (aclr)
        (!spre && cfg.registered && $stable(cfg)) |=>
        (!cfg.registered || (o.data == ($past(sum) ^ !cfg.act_high))));

endmodule

// File: rtl/mcarr_top.sv
module mcarr_top
    import mcarr_pkg::*;
#(
    parameter int NCELL = NCELL_DEF,
    localparam int NTOTAL = term_total(NCELL)
) (
    input  logic              clk,
    input  logic              pt_aclr,
    input  logic              pt_spre,
    input  logic [NTOTAL-1:0] pt_sum,
    input  logic [NCELL-1:0]  pt_oe,
    input  logic [NCELL-1:0]  cfg_reg,
    input  logic [NCELL-1:0]  cfg_pol,
    input  logic [NCELL-1:0]  pin_in,
    output logic [NCELL-1:0]  pin_out,
    output logic [NCELL-1:0]  pin_oe,
    output logic [NCELL-1:0]  fb_out
);
    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        localparam int NT   = term_count(g, NCELL);
        localparam int BASE = term_base(g, NCELL);
        cell_cfg_t c_cfg;
        cell_out_t c_out;

        assign c_cfg.registered = cfg_reg[g];
        assign c_cfg.act_high   = cfg_pol[g];

        mcarr_cell #(.NTERM(NT)) i_cell (
            .clk     (clk),
            .aclr    (pt_aclr),
            .spre    (pt_spre),
            .terms   (pt_sum[BASE +: NT]),
            .oe_term (pt_oe[g]),
            .cfg     (c_cfg),
            .pad     (pin_in[g]),
            .o       (c_out)
        );

        assign pin_out[g] = c_out.data;
        assign pin_oe[g]  = c_out.oe;
        assign fb_out[g]  = c_out.fb;
    end

    // R5: each enable pin follows its own enable term.
    a_r5_oe_tracks: assert property (@(posedge clk) disable iff (pt_aclr)
        pin_oe == pt_oe);

endmodule

// File: tb/test_mcarr_top.sv
module test_mcarr_top;
    localparam int N  = 10;
    localparam int NT = 120;

    logic          clk = 1'b0;
    logic          pt_aclr, pt_spre;
    logic [NT-1:0] pt_sum;
    logic [N-1:0]  pt_oe, cfg_reg, cfg_pol, pin_in;
    logic [N-1:0]  pin_out, pin_oe, fb_out;

    always #5 clk = ~clk;

    mcarr_top i_mcarr_top (
        .clk     (clk),
        .pt_aclr (pt_aclr),
        .pt_spre (pt_spre),
        .pt_sum  (pt_sum),
        .pt_oe   (pt_oe),
        .cfg_reg (cfg_reg),
        .cfg_pol (cfg_pol),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );

    typedef struct {
        logic [N-1:0] out;
        logic [N-1:0] oe;
        logic [N-1:0] fb;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           n_vec = 0;
    int           n_bad = 0;
    logic [N-1:0] mq;
    bit           done = 0;

    // Slice widths as given in R1.
    function automatic int width_of(input int i);
        int t[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
        return t[i];
    endfunction

    function automatic logic [N-1:0] sums(input logic [NT-1:0] v);
        logic [N-1:0] s;
        int b;
        b = 0;
        for (int i = 0; i < N; i++) begin
            s[i] = 1'b0;
            for (int k = 0; k < width_of(i); k++) s[i] |= v[b + k];
            b += width_of(i);
        end
        return s;
    endfunction

    task automatic apply(input logic aclr, input logic spre, input logic [NT-1:0] t,
                         input logic [N-1:0] oe, input logic [N-1:0] creg,
                         input logic [N-1:0] cpol, input logic [N-1:0] pad,
                         input string tag);
        logic [N-1:0] s, nq, d;
        exp_t e;
        @(negedge clk);
        pt_aclr = aclr; pt_spre = spre; pt_sum = t; pt_oe = oe;
        cfg_reg = creg; cfg_pol = cpol; pin_in = pad;
        s  = sums(t);
        nq = aclr ? '0 : (spre ? '1 : s);
        mq = nq;
        d  = (creg & nq) | (~creg & s);
        e.out = (cpol & d) | (~cpol & ~d);
        e.oe  = oe;
        e.fb  = (creg & nq) | (~creg & pad);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: one expected item per rising edge, compared just after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, pin_out, e.out);
                check("R5", pin_oe, e.oe);
                check("R8", fb_out, e.fb);
            end
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NT-1:0] rv;
        pt_aclr = 1; pt_spre = 0; pt_sum = '0; pt_oe = '0;
        cfg_reg = '1; cfg_pol = '1; pin_in = '0;
        // Reset state: cleared registers, all registered, active-high.
        apply(1, 0, '1, '0, '1, '1, '0, "R6");
        apply(1, 0, '1, '1, '1, '1, '1, "R6");
        // R1: a single term at every position lights exactly its own cell.
        for (int b = 0; b < NT; b++) apply(0, 0, NT'(1) << b, 10'h155, '0, '1, 10'h0f0, "R1");
        for (int b = 0; b < NT; b++) apply(0, 0, NT'(1) << b, 10'h2aa, '1, '1, '0, "R1");
        // R2 / R3 / R4 in uniform configurations.
        for (int i = 0; i < 30; i++) begin
            rv = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) rv = NT'(1) << ($urandom % NT);
            apply(0, 0, rv, 10'($urandom), '1, '1, 10'($urandom), "R2");
            apply(0, 0, rv, 10'($urandom), '0, '1, 10'($urandom), "R3");
            apply(0, 0, rv, 10'($urandom), '1, '0, 10'($urandom), "R4");
            apply(0, 0, rv, 10'($urandom), '0, '0, 10'($urandom), "R4");
        end
        // R9: mixed per-cell configurations.
        for (int i = 0; i < 200; i++) begin
            rv = {$urandom, $urandom, $urandom, $urandom};
            if (i % 2 == 0) rv = rv & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            apply(0, 0, rv, 10'($urandom), 10'($urandom), 10'($urandom), 10'($urandom), "R9");
        end
        // R7: preset overrides an all-zero sum.
        apply(0, 1, '0, '1, '1, '1, '0, "R7");
        apply(0, 1, '0, '1, '1, 10'h0f3, '0, "R7");
        apply(0, 0, '0, '1, '1, '1, '0, "R2");
        // R6: clear takes effect before any edge, and beats the preset.
        apply(0, 1, '0, '1, '1, '1, '0, "R7");
        @(negedge clk);
        pt_aclr = 1;
        #1;
        check("R6", pin_out, '0);
        check("R6", fb_out, '0);
        sb.push_back('{out: '0, oe: '1, fb: '0, tag: "R6"});
        apply(1, 1, '1, '1, '1, '1, '0, "R6");
        apply(0, 0, '1, '1, '1, '1, '0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule